// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is a memory-mapped general-purpose I/O controller whose pins are grouped in banks of 32. Software reaches it through a simple single-cycle register bus: a request with the write flag set updates a register on the clock edge, and a request without it returns registered read data one cycle later. Every bank has an identical register set at a fixed stride. It holds output value, output enable, pull-resistor enable and direction, and a three-bit drive-strength code per pin. That code is stored bit-sliced, one bit per pin, across three consecutive registers.

Pad inputs are resynchronised by a two-flop chain. The resynchronised levels can be read back through the bank's input register. They are also presented on a separate output so that an external interrupt sense unit can watch them. The pin count is a parameter and need not fill the last bank; absent pin positions behave as empty bits.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Bank b occupies byte addresses b*0x200 to b*0x200+0x1FF. The register within a bank is chosen by address bits [8:2], and address bits [1:0] are ignored. Pin n lives in bank n/32 at bit n mod 32.
- R2: Register 0x04 holds output values and 0x08 holds output enables, where 1 drives the pin. A write appears on pad_out_o / pad_oe_o after the clock edge that takes it, and reads back unchanged.
- R3: Each pad input passes through two flops. A level change shows on pin_level_o after the second rising edge, and is readable at offset 0x00. Writes to 0x00 have no effect.
- R4: Register 0x34 sets pull direction (1 = up, 0 = down) on pad_pull_up_o. Register 0x38 sets pull enable on pad_pull_en_o, where 0 means no bias whatever the direction bit holds.
- R5: Bit i of a pin's drive code sits at offset 0x58+4*i in the pin's bit position. The code of pin n appears on pad_drive_o[3n+2:3n]. Code c stands for (c+1)*2 mA, so 0..7 span 2..16 mA.
- R6: In a partly filled last bank, bits of absent pins read 0 and writes to them are dropped.
- R7: Any offset other than 0x00, 0x04, 0x08, 0x34, 0x38, 0x58, 0x5C, 0x60, and any bank index at or above the bank count, reads 0. Writes there change nothing.
- R8: After reset, every writable register is 0. All pins are then inputs with bias off and drive code 0 (2 mA).
- R9: rdata_o is loaded only by a read request, one edge after it, and keeps its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pad_in_i | input | NUM_PINS | Raw pad input levels |
| pad_out_o | output | NUM_PINS | Output value per pin |
| pad_oe_o | output | NUM_PINS | Output enable per pin |
| pad_pull_en_o | output | NUM_PINS | Pull resistor enable per pin |
| pad_pull_up_o | output | NUM_PINS | Pull direction per pin, 1 = up |
| pad_drive_o | output | 3*NUM_PINS | Drive code, pin n at [3n+2:3n] |
| pin_level_o | output | NUM_PINS | Synchronised input levels for interrupt sensing |

## Verification
Pad control outputs are due on the first rising edge after a write. Read data is due on the first edge after a read request, so both are sampled on the falling edge that follows. Pad inputs need two edges before pin_level_o moves. The bench therefore checks the level after one edge (still old) and after the second (new), and only then reads the input register, which adds the edge of the read. All stimulus changes on falling edges, so no sample sits on an edge that moves it.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int BANK_PINS  = 32;
  localparam int SPAN_LG    = 9;   // 0x200 byte window per bank
  localparam int WORD_W     = SPAN_LG - 2;
  localparam int DRV_BITS   = 3;

  localparam logic [WORD_W-1:0] W_DIN   = 7'd0;   // 0x00
  localparam logic [WORD_W-1:0] W_DOUT  = 7'd1;   // 0x04
  localparam logic [WORD_W-1:0] W_OE    = 7'd2;   // 0x08
  localparam logic [WORD_W-1:0] W_PSEL  = 7'd13;  // 0x34
  localparam logic [WORD_W-1:0] W_PEN   = 7'd14;  // 0x38
  localparam logic [WORD_W-1:0] W_DRV0  = 7'd22;  // 0x58, then +1, +2

  function automatic int bank_width(int pins, int bank);
    int rem;
    rem = pins - bank * BANK_PINS;
    return (rem > BANK_PINS) ? BANK_PINS : rem;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_ctrl_pkg::*;
#(
  parameter int BW = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [WORD_W-1:0]    word_i,
  input  logic [BW-1:0]        wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [BW-1:0]        din_i,
  output logic [BW-1:0]        dout_o,
  output logic [BW-1:0]        oe_o,
  output logic [BW-1:0]        pull_en_o,
  output logic [BW-1:0]        pull_up_o,
  output logic [DRV_BITS*BW-1:0] drv_o
);
  logic [BW-1:0] dout_q, oe_q, psel_q, pen_q;
  logic [BW-1:0] drv_q [DRV_BITS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      oe_q   <= '0;
      psel_q <= '0;
      pen_q  <= '0;
      for (int i = 0; i < DRV_BITS; i++) drv_q[i] <= '0;
    end else if (wr_i) begin
      case (word_i)
        W_DOUT: dout_q <= wdata_i;
        W_OE:   oe_q   <= wdata_i;
        W_PSEL: psel_q <= wdata_i;
        W_PEN:  pen_q  <= wdata_i;
        default: begin
          for (int i = 0; i < DRV_BITS; i++)
            if (word_i == W_DRV0 + WORD_W'(i)) drv_q[i] <= wdata_i;
        end
      endcase
    end
  end

  always_comb begin
    logic [BW-1:0] sel;
    sel = '0;
    case (word_i)
      W_DIN:  sel = din_i;
      W_DOUT: sel = dout_q;
      W_OE:   sel = oe_q;
      W_PSEL: sel = psel_q;
      W_PEN:  sel = pen_q;
      default: begin
        for (int i = 0; i < DRV_BITS; i++)
          if (word_i == W_DRV0 + WORD_W'(i)) sel = drv_q[i];
      end
    endcase
    rdata_o = 32'(sel);
  end

  // gather bit-sliced drive planes into per-pin codes
  always_comb begin
    for (int p = 0; p < BW; p++)
      for (int i = 0; i < DRV_BITS; i++)
        drv_o[DRV_BITS*p + i] = drv_q[i][p];
  end

  assign dout_o    = dout_q;
  assign oe_o      = oe_q;
  assign pull_en_o = pen_q;
  assign pull_up_o = psel_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [31:0]              wdata_i,
  output logic [31:0]              rdata_o,
  input  logic [NUM_PINS-1:0]      pad_in_i,
  output logic [NUM_PINS-1:0]      pad_out_o,
  output logic [NUM_PINS-1:0]      pad_oe_o,
  output logic [NUM_PINS-1:0]      pad_pull_en_o,
  output logic [NUM_PINS-1:0]      pad_pull_up_o,
  output logic [DRV_BITS*NUM_PINS-1:0] pad_drive_o,
  output logic [NUM_PINS-1:0]      pin_level_o
);
  localparam int NUM_BANKS = (NUM_PINS + BANK_PINS - 1) / BANK_PINS;
  localparam int BSEL_W    = ADDR_W - SPAN_LG;

  logic [BSEL_W-1:0] bank_idx;
  logic [WORD_W-1:0] word;
  logic [31:0]       bank_rd [NUM_BANKS];
  logic [31:0]       rd_mux, rdata_q;
  logic [NUM_PINS-1:0] din_sync;
  logic              unused_bits;

  assign bank_idx    = addr_i[ADDR_W-1:SPAN_LG];
  assign word        = addr_i[SPAN_LG-1:2];
  assign unused_bits = ^{addr_i[1:0], wdata_i};

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (din_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BW = bank_width(NUM_PINS, b);
    localparam int LO = b * BANK_PINS;
    logic hit;
    assign hit = req_i && we_i && (bank_idx == BSEL_W'(b));

    gpio_bank #(.BW(BW)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (hit),
      .word_i    (word),
      .wdata_i   (wdata_i[BW-1:0]),
      .rdata_o   (bank_rd[b]),
      .din_i     (din_sync[LO +: BW]),
      .dout_o    (pad_out_o[LO +: BW]),
      .oe_o      (pad_oe_o[LO +: BW]),
      .pull_en_o (pad_pull_en_o[LO +: BW]),
      .pull_up_o (pad_pull_up_o[LO +: BW]),
      .drv_o     (pad_drive_o[DRV_BITS*LO +: DRV_BITS*BW])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_idx == BSEL_W'(b)) rd_mux = bank_rd[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (req_i && !we_i)  rdata_q <= rd_mux;
  end

  assign rdata_o     = rdata_q;
  assign pin_level_o = din_sync;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 12
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [31:0]           wdata_i,
  input logic [31:0]           rdata_o,
  input logic [NUM_PINS-1:0]   pad_in_i,
  input logic [NUM_PINS-1:0]   pad_out_o,
  input logic [3*NUM_PINS-1:0] pad_drive_o,
  input logic [NUM_PINS-1:0]   pin_level_o
);
  localparam int B0W   = (NUM_PINS < 32) ? NUM_PINS : 32;
  localparam int NBANK = (NUM_PINS + 31) / 32;

  logic [1:0] cyc;
  logic [6:0] w;
  logic       mapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  assign w = addr_i[8:2];
  assign mapped = (int'(addr_i[ADDR_W-1:9]) < NBANK) &&
                  (w == 7'd0 || w == 7'd1 || w == 7'd2 || w == 7'd13 ||
                   w == 7'd14 || w == 7'd22 || w == 7'd23 || w == 7'd24);

  assert_dout_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[ADDR_W-1:2] == (ADDR_W-2)'(1))
    |=> pad_out_o[B0W-1:0] == $past(wdata_i[B0W-1:0]));

  assert_two_stage_sync_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2) |-> pin_level_o == $past(pad_in_i, 2));

  assert_drive_plane0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[ADDR_W-1:2] == (ADDR_W-2)'(22))
    |=> pad_drive_o[0] == $past(wdata_i[0]));

  assert_unmapped_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !mapped) |=> rdata_o == 32'd0);

  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc != 2'd0 && !(req_i && !we_i)) |=> $stable(rdata_o));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpio_bank_ctrl_test.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_test;
  localparam int NP = 40;
  localparam int AW = 12;
  localparam int NV = 12;

  localparam logic [AW-1:0] VA [NV] = '{12'h004, 12'h008, 12'h034, 12'h038, 12'h058,
    12'h204, 12'h238, 12'h000, 12'h010, 12'h044, 12'h404, 12'h007};
  localparam logic [31:0] VW [NV] = '{32'hA5A55A5A, 32'hFFFF0000, 32'h12345678,
    32'h0000FFFF, 32'h0F0F0F0F, 32'hFFFFFFFF, 32'hABCDEF12, 32'hFFFFFFFF,
    32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000011};
  localparam logic [31:0] VE [NV] = '{32'hA5A55A5A, 32'hFFFF0000, 32'h12345678,
    32'h0000FFFF, 32'h0F0F0F0F, 32'h000000FF, 32'h00000012, 32'h00000000,
    32'h00000000, 32'h00000000, 32'h00000000, 32'h00000011};

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata, rd;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe, pull_en, pull_up, lvl;
  logic [3*NP-1:0] drive;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .pad_pull_en_o(pull_en), .pad_pull_up_o(pull_up),
    .pad_drive_o(drive), .pin_level_o(lvl));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd_reg(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8: reset state
    chk("R8 oe", 32'(pad_oe), 32'h0);
    chk("R8 drive", 32'(drive), 32'h0);
    chk("R8 pull_en", 32'(pull_en), 32'h0);
    rd_reg(12'h060, rd); chk("R8 drv2 reg", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VA[i], VW[i]);
      rd_reg(VA[i], rd);
      chk($sformatf("vector %0d R1 R2 R4 R5 R6 R7", i), rd, VE[i]);
    end

    // R2/R4/R6 pad outputs after the vector walk
    chk("R2 pad_out bank0", pad_out[31:0], 32'h00000011);
    chk("R6 pad_out bank1", 32'(pad_out[39:32]), 32'hFF);
    chk("R2 pad_oe", pad_oe[31:0], 32'hFFFF0000);
    chk("R4 pull_up", pull_up[31:0], 32'h12345678);
    chk("R4 pull_en bank1", 32'(pull_en[39:32]), 32'h12);

    // R5: pin 5 code 5, pin 39 code 7
    wr(12'h058, 32'h20); wr(12'h05C, 32'h0); wr(12'h060, 32'h20);
    wr(12'h258, 32'h80); wr(12'h25C, 32'h80); wr(12'h260, 32'h80);
    chk("R5 pin5 code", 32'(drive[17:15]), 32'd5);
    chk("R5 pin39 code", 32'(drive[119:117]), 32'd7);
    chk("R5 pin0 code", 32'(drive[2:0]), 32'd0);

    // R3: two-edge synchronizer
    @(negedge clk); pad_in[3] = 1; pad_in[39] = 1;
    @(negedge clk); chk("R3 after one edge", 32'(lvl[3]), 32'd0);
    @(negedge clk); chk("R3 after two edges", 32'(lvl[3]), 32'd1);
    rd_reg(12'h000, rd); chk("R3 din bank0", rd, 32'h8);
    rd_reg(12'h200, rd); chk("R3 din bank1", rd, 32'h80);

    // R9: rdata holds through idle and writes
    @(negedge clk); chk("R9 idle hold", rdata, 32'h80);
    wr(12'h004, 32'h0); chk("R9 write hold", rdata, 32'h80);

    // R7: unmapped writes left bank0 registers alone
    rd_reg(12'h008, rd); chk("R7 oe intact", rd, 32'hFFFF0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule